// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block turns one PWM demand bit into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. It never enables a gate on a fixed timer alone. Each gate has a sense input that reports when that gate's drive is below its turn-off threshold. The opposite gate is released only after that sense input has been seen high, passed through a two-stage synchroniser, and followed by a short constant delay. The sense input for the high side is taken gate-to-switch-node. The sense input for the low side is taken gate-to-ground.

A fault controller can override the demand with two commands. Force-off drops both enables in the same cycle and leaves the output floating. Force-low-side turns the high side off and then holds the low side on, using the normal non-overlap path. If a turn-off is never confirmed by its sense input, the block stops and holds both gates off. It then raises a sticky fault flag, which only reset clears.

The delay is counted in clock cycles. `DLY_CYC` is the total number of clock edges from a sense input rising to the opposite enable rising, and it includes the synchroniser latency. The default of 4 cycles gives 40 ns at 100 MHz. The default timeout is 16 cycles. All control is synchronous, with an active-high reset.

Top module: `nonoverlap_gate_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle, under any input sequence.
- R2: `hs_en` rises only after `ls_below` (1 = low-side gate below threshold) has been high. While the block waits for the low-side gate, `hs_en` rises on exactly the `DLY_CYC`-th clock edge after `ls_below` rises.
- R3: `ls_en` rises only after `hs_below` (1 = high-side gate-to-switch-node below threshold) has been high, with the same timing as R2.
- R4: With default parameters, the dead time from the sense input rising to the opposite enable rising is 4 clock edges. This is 40 ns at 100 MHz.
- R5: With `pwm_demand` held at 0, `hs_en` never rises and `ls_en` stays on (0 % duty). With `pwm_demand` held at 1, `ls_en` stays off and `hs_en` stays on (100 % duty).
- R6: `force_off` = 1 drives both enables low combinationally, in the same cycle, whatever the state. After it is released, a gate turns on again only through the R2/R3 sequence.
- R7: `force_low_side` = 1 drives `hs_en` low in the same cycle. It then holds `ls_en` on once `hs_below` is confirmed, regardless of `pwm_demand`.
- R8: `force_off` has priority over `force_low_side`, and `force_low_side` has priority over `pwm_demand`.
- R9: An enable falls and its turn-off is then not confirmed by the sense input. In that case `sense_fault` rises on the `TIMEOUT`-th clock edge after the enable fell (16 by default), and both enables stay low.
- R10: `sense_fault` and the both-off condition are sticky. Demand and override inputs have no effect on them until `rst`.
- R11: During reset and on the first edge after it, both enables and `sense_fault` are 0. With `pwm_demand` = 0 after reset, the low side turns on through the R3 sequence.
- R12: Once a gate enable rises, it stays high for at least `SYNC_STAGES`+1 cycles (3 by default), unless an override drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_demand | input | 1 | 1 = high side wanted, 0 = low side wanted |
| force_low_side | input | 1 | Over-voltage override: high side off, low side held on |
| force_off | input | 1 | Shutdown / latched-fault override: both gates off |
| hs_below | input | 1 | Asynchronous; 1 when high-side gate-to-switch-node is below threshold |
| ls_below | input | 1 | Asynchronous; 1 when low-side gate is below threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| sense_fault | output | 1 | Sticky flag: a turn-off was not confirmed in time |

## Verification
The bench drives the sense inputs from a plant model whose gates follow their enables. It steps through a table of demand and override combinations, and each entry tells apart which input wins the priority order (R8). Directed runs measure the edge count from a sense input rising to the opposite enable rising, which separates a correct delay from one that is off by a cycle. They also measure the on-time left after a very short demand pulse. A stuck sense input keeps one gate looking high, which separates a working timeout from an endless wait. Finally, 0 % and 100 % duty are held for long runs to show that the inactive gate never twitches.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_HS_ON       = 3'd1,
        ST_LS_ON       = 3'd2,
        ST_WAIT_HS_LOW = 3'd3,  // heading to low side, waiting for high gate to fall
        ST_WAIT_LS_LOW = 3'd4,  // heading to high side, waiting for low gate to fall
        ST_DLY_TO_LS   = 3'd5,
        ST_DLY_TO_HS   = 3'd6,
        ST_FAULT       = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    function automatic int bits_for(input int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gseq_timer.sv
module gseq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gseq_pkg::*;
#(
    parameter int TMR_W      = 2,
    parameter int DLY_LOAD   = 0,
    parameter int MINON_LOAD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             want_hs,
    input  logic             want_ls,
    input  logic             force_off,
    input  logic             hb_s,
    input  logic             lb_s,
    input  logic             dly_done,
    input  logic             wd_done,
    output seq_state_t       state,
    output logic             dly_load,
    output logic [TMR_W-1:0] dly_val,
    output logic             wd_load
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        if (state == ST_FAULT) begin
            nxt = ST_FAULT;
        end else if (force_off) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF: begin
                    if (want_hs)      nxt = ST_WAIT_LS_LOW;
                    else if (want_ls) nxt = ST_WAIT_HS_LOW;
                end
                ST_HS_ON:
                    if (!want_hs && dly_done) nxt = ST_WAIT_HS_LOW;
                ST_LS_ON:
                    if (!want_ls && dly_done) nxt = ST_WAIT_LS_LOW;
                ST_WAIT_HS_LOW: begin
                    if (want_hs)      nxt = ST_WAIT_LS_LOW;
                    else if (hb_s)    nxt = ST_DLY_TO_LS;
                    else if (wd_done) nxt = ST_FAULT;
                end
                ST_WAIT_LS_LOW: begin
                    if (want_ls)      nxt = ST_WAIT_HS_LOW;
                    else if (lb_s)    nxt = ST_DLY_TO_HS;
                    else if (wd_done) nxt = ST_FAULT;
                end
                ST_DLY_TO_LS: begin
                    if (want_hs)       nxt = ST_WAIT_LS_LOW;
                    else if (dly_done) nxt = ST_LS_ON;
                end
                ST_DLY_TO_HS: begin
                    if (want_ls)       nxt = ST_WAIT_HS_LOW;
                    else if (dly_done) nxt = ST_HS_ON;
                end
                default: nxt = ST_FAULT;
            endcase
        end
    end

    // timer reload on entry to a delay or on-state
    always_comb begin
        dly_load = 1'b0;
        dly_val  = '0;
        if (nxt != state) begin
            case (nxt)
                ST_DLY_TO_LS, ST_DLY_TO_HS: begin
                    dly_load = 1'b1;
                    dly_val  = TMR_W'(DLY_LOAD);
                end
                ST_HS_ON, ST_LS_ON: begin
                    dly_load = 1'b1;
                    dly_val  = TMR_W'(MINON_LOAD);
                end
                default: ;
            endcase
        end
    end

    assign wd_load = !(state == ST_WAIT_HS_LOW || state == ST_WAIT_LS_LOW);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    // R2: entry into the high-side delay needs a confirmed low-side gate
    assert_hs_needs_ls_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_DLY_TO_HS) |-> $past(lb_s));
    // R3: entry into the low-side delay needs a confirmed high-side gate
    assert_ls_needs_hs_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_DLY_TO_LS) |-> $past(hb_s));
    // R4: an on-state follows only an expired delay
    assert_hs_after_delay_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_HS_ON) |-> ($past(state) == ST_DLY_TO_HS && $past(dly_done)));
    assert_ls_after_delay_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_LS_ON) |-> ($past(state) == ST_DLY_TO_LS && $past(dly_done)));
    // R6: shutdown parks the sequencer
    assert_off_parks_R6: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (state == ST_OFF || state == ST_FAULT));
    // R9: a fault is entered only after the watchdog expires
    assert_fault_on_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_FAULT) |-> $past(wd_done));
    // R10: the fault state is held until reset
    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT) |=> (state == ST_FAULT));
endmodule

// File: rtl/nonoverlap_gate_seq.sv
module nonoverlap_gate_seq
    import gseq_pkg::*;
#(
    parameter int DLY_CYC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_demand,
    input  logic force_low_side,
    input  logic force_off,
    input  logic hs_below,
    input  logic ls_below,
    output logic hs_en,
    output logic ls_en,
    output logic sense_fault
);
    localparam int PIPE_LAT   = SYNC_STAGES + 2;
    localparam int DLY_LOAD   = (DLY_CYC > PIPE_LAT) ? (DLY_CYC - PIPE_LAT) : 0;
    localparam int MINON_LOAD = SYNC_STAGES;
    localparam int TMR_W      = bits_for(max_of(DLY_LOAD, MINON_LOAD));
    localparam int WD_LOAD    = (TIMEOUT > 1) ? (TIMEOUT - 1) : 0;
    localparam int WD_W       = bits_for(WD_LOAD);

    gate_pair_t       raw_below, syn_below;
    seq_state_t       state;
    logic             want_hs, want_ls;
    logic             dly_load, dly_done, wd_load, wd_done;
    logic [TMR_W-1:0] dly_val;

    assign raw_below = '{hs: hs_below, ls: ls_below};

    // priority: force_off > force_low_side > pwm_demand
    assign want_hs = pwm_demand & ~force_low_side & ~force_off;
    assign want_ls = ~want_hs & ~force_off;

    gseq_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_below),
        .q   (syn_below)
    );

    gseq_timer #(.W(TMR_W)) i_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    gseq_timer #(.W(WD_W)) i_wd (
        .clk      (clk),
        .rst      (rst),
        .load     (wd_load),
        .load_val (WD_W'(WD_LOAD)),
        .done     (wd_done)
    );

    gseq_fsm #(
        .TMR_W      (TMR_W),
        .DLY_LOAD   (DLY_LOAD),
        .MINON_LOAD (MINON_LOAD)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .want_hs   (want_hs),
        .want_ls   (want_ls),
        .force_off (force_off),
        .hb_s      (syn_below.hs),
        .lb_s      (syn_below.ls),
        .dly_done  (dly_done),
        .wd_done   (wd_done),
        .state     (state),
        .dly_load  (dly_load),
        .dly_val   (dly_val),
        .wd_load   (wd_load)
    );

    assign hs_en       = (state == ST_HS_ON) & ~force_off & ~force_low_side;
    assign ls_en       = (state == ST_LS_ON) & ~force_off;
    assign sense_fault = (state == ST_FAULT);

    // R1: the two gates never overlap
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));
    // R11: the sequencer leaves reset with both gates off
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $fell(rst) |-> (!hs_en && !ls_en && !sense_fault));
endmodule

// File: tb/test_nonoverlap_gate_seq.sv
`timescale 1ns/100ps
module test_nonoverlap_gate_seq;
    localparam int DLY_CYC = 4;
    localparam int SYNC_ST = 2;
    localparam int TMO     = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm = 1'b0, fls = 1'b0, foff = 1'b0;
    logic hb = 1'b1, lb = 1'b1;
    logic stuck_ls = 1'b0;
    logic hs_en, ls_en, sense_fault;

    int checks = 0, errors = 0;
    int overlaps = 0, bad_rise = 0;
    logic hs_prev = 1'b0, ls_prev = 1'b0, lb_prev = 1'b0, hb_prev = 1'b0;

    always #2 clk = ~clk;

    nonoverlap_gate_seq i_nonoverlap_gate_seq (
        .clk(clk), .rst(rst), .pwm_demand(pwm), .force_low_side(fls),
        .force_off(foff), .hs_below(hb), .ls_below(lb),
        .hs_en(hs_en), .ls_en(ls_en), .sense_fault(sense_fault)
    );

    // plant: each gate follows its enable by half a cycle
    always @(negedge clk) begin
        hb <= !hs_en;
        lb <= stuck_ls ? 1'b0 : !ls_en;
    end

    // monitor for R1, R2, R3
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (hs_en && ls_en) overlaps++;
            if (hs_en && !hs_prev && !(lb && lb_prev)) bad_rise++;
            if (ls_en && !ls_prev && !(hb && hb_prev)) bad_rise++;
        end
        hs_prev = hs_en; ls_prev = ls_en; lb_prev = lb; hb_prev = hb;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
        end
    endtask

    typedef struct packed {
        logic pwm;
        logic fls;
        logic foff;
        logic exp_hs;
        logic exp_ls;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 low side
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 high side
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 override beats pwm
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R8 off beats low-side
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        string tag;
        // R11 reset state
        tick(3);
        chk("R11 hs_en in reset", hs_en, 0);
        chk("R11 ls_en in reset", ls_en, 0);
        chk("R11 fault in reset", sense_fault, 0);
        rst = 1'b0;
        tick(1);
        chk("R11 hs_en after reset", hs_en, 0);
        tick(11);
        chk("R11 low side on after reset", ls_en, 1);

        // table walk: R5, R6, R7, R8
        foreach (VECS[k]) begin
            pwm = VECS[k].pwm; fls = VECS[k].fls; foff = VECS[k].foff;
            tag = VECS[k].foff ? "R8" : (VECS[k].fls ? "R7" : "R5");
            tick(12);
            chk({tag, " hs_en"}, hs_en, VECS[k].exp_hs);
            chk({tag, " ls_en"}, ls_en, VECS[k].exp_ls);
        end

        // R4 / R2: dead time low->high, from ls_below rising
        pwm = 1'b0; tick(12);
        pwm = 1'b1;
        cnt = 0;
        while (!lb) tick(1);
        while (!hs_en && cnt < 50) begin tick(1); cnt++; end
        chk("R4 R2 edges ls_below->hs_en", cnt, DLY_CYC);

        // R3: dead time high->low
        tick(12);
        pwm = 1'b0;
        cnt = 0;
        while (!hb) tick(1);
        while (!ls_en && cnt < 50) begin tick(1); cnt++; end
        chk("R3 edges hs_below->ls_en", cnt, DLY_CYC);

        // R6: shutdown is immediate, mid-cycle
        tick(12);
        foff = 1'b1; #0.5;
        chk("R6 ls_en immediate", ls_en, 0);
        chk("R6 hs_en immediate", hs_en, 0);
        tick(4); foff = 1'b0; tick(12);
        chk("R6 restart to low side", ls_en, 1);

        // R7: low-side force drops the high side at once
        pwm = 1'b1; tick(12);
        fls = 1'b1; #0.5;
        chk("R7 hs_en immediate", hs_en, 0);
        tick(12);
        chk("R7 ls_en held", ls_en, 1);
        fls = 1'b0; pwm = 1'b0; tick(12);

        // R12: minimum on-time after a short pulse
        pwm = 1'b1;
        cnt = 0;
        while (!hs_en && cnt < 50) begin tick(1); cnt++; end
        pwm = 1'b0;
        cnt = 0;
        while (hs_en && cnt < 50) begin cnt++; tick(1); end
        chk("R12 min on-time", cnt, SYNC_ST + 1);

        // R5: long 0% then 100% runs
        tick(12);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin tick(1); if (hs_en || !ls_en) cnt++; end
        chk("R5 zero duty", cnt, 0);
        pwm = 1'b1; tick(12);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin tick(1); if (ls_en || !hs_en) cnt++; end
        chk("R5 full duty", cnt, 0);

        // R9: low-side gate never confirms low
        pwm = 1'b0; tick(12);
        stuck_ls = 1'b1; tick(2);
        pwm = 1'b1;
        cnt = 0;
        while (!sense_fault && cnt < 100) begin tick(1); cnt++; end
        chk("R9 timeout edges", cnt, TMO + 1);
        chk("R9 hs_en off", hs_en, 0);
        chk("R9 ls_en off", ls_en, 0);

        // R10: sticky against all inputs until reset
        stuck_ls = 1'b0;
        pwm = 1'b0; tick(10); pwm = 1'b1; fls = 1'b1; tick(10); fls = 1'b0; tick(10);
        chk("R10 fault held", sense_fault, 1);
        chk("R10 hs_en held off", hs_en, 0);
        chk("R10 ls_en held off", ls_en, 0);
        rst = 1'b1; tick(3); rst = 1'b0; tick(1);
        chk("R10 fault cleared by reset", sense_fault, 0);
        tick(15);
        chk("R10 resumes high side", hs_en, 1);

        chk("R1 overlap count", overlaps, 0);
        chk("R2 R3 unconfirmed rises", bad_rise, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule